// File: doc/BRIEF.md
# Two-Rate Vernier Round-Trip Timer

This block estimates a round-trip delay and a one-way distance from two low-rate pulse trains whose rates differ by about a tenth of a percent. A reference train and a returned (delayed) train arrive as single-cycle strobes already aligned to the system clock. Because the returned train is slightly faster, its pulses slide past the reference pulses at a small step per period, and the slip is counted across three consecutive phases instead of timing the delay with a fast clock.

After an accepted start, three saturating counters record the pulses of each phase. A short arithmetic pipeline then forms a signed time estimate in picoseconds, with half of the middle count credited to each train, subtracts the target's fixed turnaround time and scales the rest to millimetres. A counter running out of range aborts the measurement and flags the results as invalid. All results stay on the outputs until the next accepted start.

Top module: `vernier_ranger`

## Requirements
- R1: After reset, counts, time, distance, `done`, `valid` and `overflow` are all zero.
- R2: After an accepted start, counter 1 counts reference strobes up to and including the cycle of the first delayed strobe; that delayed strobe ends phase 1.
- R3: A reference strobe is coincident when a delayed strobe occurs in the same cycle or up to `WIN` cycles before it. In phase 2, counter 2 counts coincident reference strobes; non-coincident ones before the first coincidence are ignored, and the first non-coincident one after a coincidence ends phase 2.
- R4: In phase 3, counter 3 counts delayed strobes; the delayed strobe that has a reference strobe in its own cycle or up to `WIN` cycles before it is counted and completes the measurement.
- R5: `tx_ps` = floor(((2·N3 + N2)·T_DLY − (2·N1 + N2)·T_REF) / 2), signed picoseconds, where T_REF and T_DLY are the period parameters.
- R6: `dist_mm` = floor((D·C_Q + 2^FRAC) / 2^(FRAC+1)) with D = `tx_ps` − t0, C_Q = 5029675 and FRAC = 24 by default; t0 is the value of `t0_ps` captured with the accepted start.
- R7: When `tx_ps` is below the captured t0, `dist_mm` is 0 and `valid` is still 1.
- R8: `done` and `valid` rise on the third clock edge after the edge that samples the completing delayed strobe.
- R9: A strobe that would step a counter already at its maximum aborts the measurement: that counter holds its maximum, and on the next edge `done`=1, `overflow`=1, `valid`=0, `tx_ps`=0 and `dist_mm`=0.
- R10: A start request is ignored while a measurement is being counted or computed.
- R11: An accepted start clears all results and `done` on the next edge; after `done`, results hold and strobes have no effect until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Measurement request, accepted only when idle |
| ref_stb | input | 1 | Reference train strobe, one cycle wide |
| dly_stb | input | 1 | Returned train strobe, one cycle wide |
| t0_ps | input | TX_W | Target turnaround time in picoseconds |
| n1 | output | CNT_W | Phase 1 count |
| n2 | output | CNT_W | Phase 2 count |
| n3 | output | CNT_W | Phase 3 count |
| tx_ps | output | TX_W | Signed time estimate in picoseconds |
| dist_mm | output | DIST_W | One-way distance in millimetres |
| done | output | 1 | Measurement finished or aborted |
| valid | output | 1 | Time and distance are meaningful |
| overflow | output | 1 | Measurement aborted by a full counter |

## Verification
The completing delayed strobe is sampled on one edge, the time estimate is registered on the next, the clamped product on the one after and the distance with `done` on the third, so the bench records the cycle in which it drove the completing strobe and expects `done` exactly four of its falling-edge sample points later. An abort shows one edge after the sampling edge, two sample points after the overflowing strobe was driven. Start clearing is checked at the first sample point after the start edge, and every strobe schedule is chosen so the bench knows in advance which strobe ends each phase.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FIRST,
    PH_SEEK,
    PH_COIN,
    PH_TAIL,
    PH_CALC
  } phase_t;
endpackage

// File: rtl/vr_strobe_age.sv
module vr_strobe_age #(
  parameter int AGE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             stb,
  output logic [AGE_W-1:0] age
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [AGE_W-1:0] age_q;

  // cycles since the most recent strobe, counting the present cycle as 0
  always_comb begin
    if (stb)                  age = '0;
    else if (age_q == AGE_MAX) age = AGE_MAX;
    else                      age = age_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) age_q <= AGE_MAX;
    else            age_q <= age;
  end
endmodule

// File: rtl/vr_sat_count.sv
module vr_sat_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         full
);
  assign full = &cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (inc && !full) cnt <= cnt + 1'b1;
  end

  // R9: a full counter holds its value
  a_r9_counter_holds: assert property (@(posedge clk) disable iff (rst)
    (inc && full && !clr) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/vr_phase_ctrl.sv
module vr_phase_ctrl
  import vr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WIN   = 2,
  parameter int AGE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ref_stb,
  input  logic             dly_stb,
  input  logic [AGE_W-1:0] ref_age,
  input  logic [AGE_W-1:0] dly_age,
  input  logic             fin,
  output logic [CNT_W-1:0] n1,
  output logic [CNT_W-1:0] n2,
  output logic [CNT_W-1:0] n3,
  output logic             acc,
  output logic             go,
  output logic             abort
);
  localparam int NCNT = 3;
  localparam logic [AGE_W-1:0] WIN_A = AGE_W'(WIN);

  phase_t state;
  logic [NCNT-1:0]  inc;
  logic [NCNT-1:0]  full;
  logic [CNT_W-1:0] cnt [NCNT];
  logic coinc, closing, ovf_hit;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    vr_sat_count #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (acc),
      .inc  (inc[g]),
      .cnt  (cnt[g]),
      .full (full[g])
    );
  end

  assign n1 = cnt[0];
  assign n2 = cnt[1];
  assign n3 = cnt[2];

  assign acc     = start && (state == PH_IDLE);
  assign coinc   = ref_stb && (dly_age <= WIN_A);
  assign closing = dly_stb && (ref_age <= WIN_A);

  assign inc[0] = (state == PH_FIRST) && ref_stb;
  assign inc[1] = ((state == PH_SEEK) || (state == PH_COIN)) && coinc;
  assign inc[2] = (state == PH_TAIL) && dly_stb;
  assign ovf_hit = |(inc & full);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_IDLE;
      go    <= 1'b0;
      abort <= 1'b0;
    end else begin
      go    <= 1'b0;
      abort <= 1'b0;
      if (ovf_hit) begin
        state <= PH_CALC;
        abort <= 1'b1;
      end else begin
        case (state)
          PH_IDLE:  if (acc) state <= PH_FIRST;
          PH_FIRST: if (dly_stb) state <= PH_SEEK;
          PH_SEEK:  if (coinc) state <= PH_COIN;
          PH_COIN:  if (ref_stb && !coinc) state <= PH_TAIL;
          PH_TAIL:  if (closing) begin
                      state <= PH_CALC;
                      go    <= 1'b1;
                    end
          PH_CALC:  if (fin) state <= PH_IDLE;
          default:  state <= PH_IDLE;
        endcase
      end
    end
  end

  // R10: counts never fall while a measurement is under way
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state != PH_IDLE) |=> (n1 >= $past(n1)) && (n2 >= $past(n2)) && (n3 >= $past(n3)));

  // R3: same-cycle strobes while searching are a coincidence
  a_r3_same_cycle: assert property (@(posedge clk) disable iff (rst)
    (state == PH_SEEK && ref_stb && dly_stb && !full[1]) |=> (state == PH_COIN));

  // R4: phase 3 moves only on delayed strobes
  a_r4_tail_delayed_only: assert property (@(posedge clk) disable iff (rst)
    (state == PH_TAIL && !dly_stb) |=> (n3 == $past(n3)));

  // R2: phase 1 never advances counter 2 or 3
  a_r2_first_only_c1: assert property (@(posedge clk) disable iff (rst)
    (state == PH_FIRST) |=> (n2 == '0) && (n3 == '0));
endmodule

// File: rtl/vr_estimator.sv
module vr_estimator #(
  parameter int CNT_W      = 16,
  parameter int TX_W       = 40,
  parameter int DIST_W     = 32,
  parameter int REF_PER_PS = 400000,
  parameter int DLY_PER_PS = 399600,
  parameter int C_Q        = 5029675,
  parameter int FRAC       = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     go,
  input  logic                     abort,
  input  logic [TX_W-1:0]          t0,
  input  logic [CNT_W-1:0]         n1,
  input  logic [CNT_W-1:0]         n2,
  input  logic [CNT_W-1:0]         n3,
  output logic signed [TX_W-1:0]   tx_ps,
  output logic [DIST_W-1:0]        dist_mm,
  output logic                     done,
  output logic                     valid,
  output logic                     ovf,
  output logic                     fin
);
  localparam int PW = 64;
  localparam logic [PW-1:0] ROUND_ADD = PW'(1) << FRAC;

  logic [TX_W-1:0]        t0_q;
  logic                   s1, s2;
  logic [PW-1:0]          prod_q;
  logic [PW-1:0]          up_w, dn_w;
  logic signed [PW-1:0]   dif2_w, diff_w;

  // doubled time avoids the half-count fractions
  always_comb begin
    up_w   = (2 * PW'(n3) + PW'(n2)) * PW'(DLY_PER_PS);
    dn_w   = (2 * PW'(n1) + PW'(n2)) * PW'(REF_PER_PS);
    dif2_w = $signed(up_w) - $signed(dn_w);
    diff_w = PW'(tx_ps) - $signed(PW'(t0_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t0_q    <= '0;
      s1      <= 1'b0;
      s2      <= 1'b0;
      prod_q  <= '0;
      tx_ps   <= '0;
      dist_mm <= '0;
      done    <= 1'b0;
      valid   <= 1'b0;
      ovf     <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      s1  <= go;
      s2  <= s1;
      if (clr) begin
        t0_q    <= t0;
        tx_ps   <= '0;
        dist_mm <= '0;
        done    <= 1'b0;
        valid   <= 1'b0;
        ovf     <= 1'b0;
      end else if (abort) begin
        tx_ps   <= '0;
        dist_mm <= '0;
        done    <= 1'b1;
        valid   <= 1'b0;
        ovf     <= 1'b1;
        fin     <= 1'b1;
      end else begin
        if (go) tx_ps <= TX_W'(dif2_w >>> 1);
        if (s1) prod_q <= (diff_w < 0) ? '0 : PW'(diff_w * $signed(PW'(C_Q)));
        if (s2) begin
          dist_mm <= DIST_W'((prod_q + ROUND_ADD) >> (FRAC + 1));
          done    <= 1'b1;
          valid   <= 1'b1;
          fin     <= 1'b1;
        end
      end
    end
  end

  // R9: an aborted result is never marked valid
  a_r9_abort_invalid: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (done && !valid));

  // R8: result follows the last pipeline stage by one edge
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    (s2 && !clr && !abort) |=> (done && valid));

  // R7: time short of the turnaround yields zero distance
  a_r7_clamp: assert property (@(posedge clk) disable iff (rst)
    (done && valid && ($signed(PW'(tx_ps)) < $signed(PW'(t0_q)))) |-> (dist_mm == '0));
endmodule

// File: rtl/vernier_ranger.sv
module vernier_ranger
  import vr_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TX_W       = 40,
  parameter int DIST_W     = 32,
  parameter int WIN        = 2,
  parameter int REF_PER_PS = 400000,
  parameter int DLY_PER_PS = 399600,
  parameter int C_Q        = 5029675,
  parameter int FRAC       = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   ref_stb,
  input  logic                   dly_stb,
  input  logic [TX_W-1:0]        t0_ps,
  output logic [CNT_W-1:0]       n1,
  output logic [CNT_W-1:0]       n2,
  output logic [CNT_W-1:0]       n3,
  output logic signed [TX_W-1:0] tx_ps,
  output logic [DIST_W-1:0]      dist_mm,
  output logic                   done,
  output logic                   valid,
  output logic                   overflow
);
  localparam int AGE_W = $clog2(WIN + 2) + 1;

  logic [AGE_W-1:0] ref_age, dly_age;
  logic acc, go, abort, fin;

  vr_strobe_age #(.AGE_W(AGE_W)) u_ref_age (
    .clk (clk), .rst (rst), .clr (acc), .stb (ref_stb), .age (ref_age)
  );

  vr_strobe_age #(.AGE_W(AGE_W)) u_dly_age (
    .clk (clk), .rst (rst), .clr (acc), .stb (dly_stb), .age (dly_age)
  );

  vr_phase_ctrl #(.CNT_W(CNT_W), .WIN(WIN), .AGE_W(AGE_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ref_stb (ref_stb),
    .dly_stb (dly_stb),
    .ref_age (ref_age),
    .dly_age (dly_age),
    .fin     (fin),
    .n1      (n1),
    .n2      (n2),
    .n3      (n3),
    .acc     (acc),
    .go      (go),
    .abort   (abort)
  );

  vr_estimator #(
    .CNT_W (CNT_W), .TX_W (TX_W), .DIST_W (DIST_W),
    .REF_PER_PS (REF_PER_PS), .DLY_PER_PS (DLY_PER_PS),
    .C_Q (C_Q), .FRAC (FRAC)
  ) u_est (
    .clk     (clk),
    .rst     (rst),
    .clr     (acc),
    .go      (go),
    .abort   (abort),
    .t0      (t0_ps),
    .n1      (n1),
    .n2      (n2),
    .n3      (n3),
    .tx_ps   (tx_ps),
    .dist_mm (dist_mm),
    .done    (done),
    .valid   (valid),
    .ovf     (overflow),
    .fin     (fin)
  );

  // R11: finished results hold while no start arrives
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(tx_ps) && $stable(dist_mm)
                          && $stable(n1) && $stable(n2) && $stable(n3)));

  // R11: an accepted start clears done on the next edge
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    acc |=> (!done && !valid && !overflow));
endmodule

// File: tb/tb_vernier_ranger.sv
`timescale 1ns/1ps
module tb_vernier_ranger;
  localparam int CNT_W = 6;
  localparam int TX_W  = 40;
  localparam int DW    = 32;
  localparam int TREF  = 160000;  // 40 cycles of 4 ns
  localparam int TDLY  = 156000;  // 39 cycles of 4 ns
  localparam int PREF  = 40;
  localparam int PDLY  = 39;
  localparam int R0    = 5;

  logic clk = 1'b0;
  logic rst, start, ref_stb, dly_stb;
  logic [TX_W-1:0] t0_ps;
  logic [CNT_W-1:0] n1, n2, n3;
  logic signed [TX_W-1:0] tx_ps;
  logic [DW-1:0] dist_mm;
  logic done, valid, overflow;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vernier_ranger #(
    .CNT_W(CNT_W), .TX_W(TX_W), .DIST_W(DW), .WIN(2),
    .REF_PER_PS(TREF), .DLY_PER_PS(TDLY), .C_Q(5029675), .FRAC(24)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .ref_stb(ref_stb), .dly_stb(dly_stb),
    .t0_ps(t0_ps), .n1(n1), .n2(n2), .n3(n3), .tx_ps(tx_ps), .dist_mm(dist_mm),
    .done(done), .valid(valid), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_tx(input int a, input int b, input int c);
    longint d2;
    d2 = (2 * longint'(c) + b) * TDLY - (2 * longint'(a) + b) * TREF;
    return d2 >>> 1;
  endfunction

  function automatic longint exp_dist(input longint tx, input longint t0);
    longint d;
    d = tx - t0;
    if (d < 0) return 0;
    return (d * 5029675 + (longint'(1) << 24)) >>> 25;
  endfunction

  // One measurement: reference strobes at t = R0 + 40k, delayed strobes at
  // t = R0 + off + 39j. tf is the t of the strobe that ends the run and lat
  // the number of sample points from driving it to seeing done.
  task automatic run_meas(input string tag, input int off, input bit dly_on,
                          input longint t0v, input int extra_start,
                          input int e1, input int e2, input int e3,
                          input int tf, input int lat, input bit e_ovf);
    int done_t;
    longint etx, edist;
    done_t = -1;
    t0_ps = TX_W'(t0v);
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (t == 1) begin
        // R11: accepted start cleared the previous results
        chk(!done && !valid && !overflow, "R11", {tag, " cleared flags"},
            longint'({done, valid, overflow}), 0);
        chk(n1 == 0 && n2 == 0 && n3 == 0 && dist_mm == 0, "R11",
            {tag, " cleared results"}, longint'(n1) + n2 + n3 + dist_mm, 0);
      end
      if (t > 1 && done) begin
        done_t = t;
        break;
      end
      start   = (t == 0) || (t == extra_start);
      ref_stb = (t >= R0) && ((t - R0) % PREF == 0);
      dly_stb = dly_on && (t >= R0 + off) && ((t - R0 - off) % PDLY == 0);
    end
    start = 1'b0; ref_stb = 1'b0; dly_stb = 1'b0;
    if (done_t < 0) begin
      chk(1'b0, "R8", {tag, " watchdog, done never rose"}, 0, 1);
      return;
    end
    chk(done_t == tf + lat, e_ovf ? "R9" : "R8", {tag, " done latency"}, done_t, tf + lat);
    chk(n1 == e1, "R2", {tag, " n1"}, n1, e1);
    chk(n2 == e2, "R3", {tag, " n2"}, n2, e2);
    chk(n3 == e3, "R4", {tag, " n3"}, n3, e3);
    chk(overflow == e_ovf, "R9", {tag, " overflow"}, overflow, e_ovf);
    chk(valid == !e_ovf, "R9", {tag, " valid"}, valid, !e_ovf);
    etx   = e_ovf ? 0 : exp_tx(e1, e2, e3);
    edist = e_ovf ? 0 : exp_dist(etx, t0v);
    chk(longint'(tx_ps) == etx, "R5", {tag, " tx_ps"}, longint'(tx_ps), etx);
    chk(longint'(dist_mm) == edist, (edist == 0) ? "R7" : "R6", {tag, " dist_mm"},
        longint'(dist_mm), edist);
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset;
    rst = 1'b1; start = 1'b0; ref_stb = 1'b0; dly_stb = 1'b0; t0_ps = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(n1 == 0 && n2 == 0 && n3 == 0, "R1", "reset counts", longint'(n1) + n2 + n3, 0);
    chk(tx_ps == 0 && dist_mm == 0, "R1", "reset results", longint'(dist_mm), 0);
    chk(!done && !valid && !overflow, "R1", "reset flags",
        longint'({done, valid, overflow}), 0);
  endtask

  // R11: strobes after done change nothing
  task automatic test_idle_strobes;
    logic [CNT_W-1:0] a, b, c;
    logic signed [TX_W-1:0] tq;
    logic [DW-1:0] dq;
    a = n1; b = n2; c = n3; tq = tx_ps; dq = dist_mm;
    for (int t = 0; t < 120; t++) begin
      @(negedge clk);
      ref_stb = (t % 7 == 0);
      dly_stb = (t % 5 == 0);
    end
    ref_stb = 1'b0; dly_stb = 1'b0;
    @(negedge clk);
    chk(n1 == a && n2 == b && n3 == c, "R11", "idle strobes counts",
        longint'(n1) + n2 + n3, longint'(a) + b + c);
    chk(tx_ps == tq && dist_mm == dq && done && valid, "R11", "idle strobes results",
        longint'(dist_mm), longint'(dq));
  endtask

  initial begin
    test_reset();
    // R2 R3 R4 R5 R6 R8: delayed train lags by 5 cycles
    run_meas("lag5", 5, 1'b1, 5000000, -1, 1, 3, 35, R0 + 5 + PDLY * 43, 4, 1'b0);
    // R3: first delayed strobe shares its cycle with a reference strobe
    run_meas("lag0", 0, 1'b1, 5000000, -1, 1, 2, 35, R0 + PDLY * 38, 4, 1'b0);
    // R7: turnaround larger than the time estimate
    run_meas("lag45", 45, 1'b1, 6000000, -1, 2, 3, 35, R0 + 45 + PDLY * 43, 4, 1'b0);
    // R10: extra start while counting phase 2
    run_meas("restart_mid", 5, 1'b1, 5000000, 200, 1, 3, 35, R0 + 5 + PDLY * 43, 4, 1'b0);
    // R10: extra start while the pipeline computes
    run_meas("restart_calc", 5, 1'b1, 5000000, R0 + 5 + PDLY * 43 + 2,
             1, 3, 35, R0 + 5 + PDLY * 43, 4, 1'b0);
    test_idle_strobes();
    // R9: no delayed train, counter 1 runs out after 63 strobes
    run_meas("overflow", 0, 1'b0, 0, -1, 63, 0, 0, R0 + PREF * 63, 2, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 60000);
    checks++;
    errors++;
    $display("FAIL watchdog: got %0d cycles expected under 60000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule